// File: doc/BRIEF.md
# One-Line Eight-Channel Audio Deserializer

This block receives a serial audio stream that carries eight channels on two data lines. The stream is framed by a word clock. Each word-clock half is 128 bit clocks long. On the main line, each half carries three 24-bit samples back to back. On the auxiliary line, each half carries one 24-bit sample. The block turns these into eight parallel 24-bit channel words and raises a one-cycle strobe when a complete frame is available.

The bit clock, the word clock and both data lines are treated as asynchronous pins. Each is synchronised into the system clock domain and sampled there. A rising edge of the synchronised bit clock is the sampling instant. A change of the word-clock level seen at such an edge marks the start of a half. The block also tracks how long each half is, and keeps a sticky flag when a half is not 128 bit clocks long. Two conditions apply: each bit-clock phase must last at least two system clocks, and the bit clock must be slower than a quarter of the system clock.

Top module: `olm_deser`

## Requirements
- R1: While `rst_n` is low at a system clock edge, every channel word, the strobe and the error flag are driven to zero.
- R2: The first rising bit-clock edge that sees a new word-clock level is the boundary edge. The next rising edge takes data bit 0, and later edges take bits 1, 2 and so on. In a half with the word clock low, main-line bits 0..23 form channel 1, bits 24..47 form channel 3 and bits 48..71 form channel 5. Each channel is sent MSB first. Channel n is output on `ch_o[24*(n-1) +: 24]`.
- R3: In a half with the word clock high, main-line bits 0..23, 24..47 and 48..71 form channels 2, 4 and 6, each MSB first.
- R4: On the auxiliary line, bits 0..23 form channel 7 when the word clock is low and channel 8 when it is high, MSB first.
- R5: The following bits change no channel word: main-line bits 72 and above, auxiliary-line bits 24 and above, and the bit taken at the boundary edge.
- R6: `frame_vld_o` is high for exactly one system clock per frame. It rises when channel 6 is written, but only if channel 5 was written in the word-clock-low half just before. A high half that follows the first lock, with no low half before it, gives no strobe.
- R7: `frame_err_o` is set at a boundary edge when the half that just ended did not span exactly 128 bit-clock rising edges. The first boundary after reset is never checked. Once set, the flag stays set until reset.
- R8: Channel words keep their values between captures. Nothing is captured before the first boundary edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| wclk_i | input | 1 | Word clock: low for the odd-channel half, high for the even-channel half |
| sd_main_i | input | 1 | Serial data line carrying channels 1 to 6 |
| sd_aux_i | input | 1 | Serial data line carrying channels 7 and 8 |
| ch_o | output | 192 | Eight 24-bit channel words; channel n sits at bits 24*(n-1) and up |
| frame_vld_o | output | 1 | One-cycle strobe when a frame is complete |
| frame_err_o | output | 1 | Sticky flag for a half of the wrong length |

## Verification
Several properties are checked on every cycle. The strobe and each lane's capture pulse last a single cycle. The error flag never clears and stays low until the framing has locked. No capture happens before lock, the channel words are stable in any cycle without a capture, and the strobe fires only in a word-clock-high half. The bench scenarios cover the rest: the bit-to-channel mapping and MSB ordering, the discarding of padding bits, the need for a preceding low half before a strobe, and the detection of halves that are too short or too long. These are checked by driving whole frames with known words and comparing the eight outputs with values computed in the bench.

// File: rtl/olm_pkg.sv
// Package olm_pkg
// Shared constants for the one-line deserializer. Assumes 24-bit samples
// and a 256x bit clock, i.e. 128 bit clocks per word-clock half.
package olm_pkg;
    parameter int unsigned SAMPLE_W   = 24;  // bits per channel word
    parameter int unsigned HALF_BCLK  = 128; // bit clocks per word-clock half
    parameter int unsigned MAIN_SLOTS = 3;   // channels per half on main line
    parameter int unsigned AUX_SLOTS  = 1;   // channels per half on aux line
endpackage

// File: rtl/olm_sync.sv
// Module olm_sync
// Two-flop synchroniser for the bit clock (bit 0) and the other serial
// pins. Produces a one-cycle pulse on each synchronised bit-clock rise.
// Assumes each bit-clock phase lasts at least two system clocks.
module olm_sync #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-2:0] data_o,
    output logic         rise_o
);
    logic [N-1:0] s1_q, s2_q;
    logic         bclk_d_q;

    // Purpose: double-register the pins and keep a delayed bit-clock copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q     <= '0;
            s2_q     <= '0;
            bclk_d_q <= 1'b0;
        end else begin
            s1_q     <= raw_i;
            s2_q     <= s1_q;
            bclk_d_q <= s2_q[0];
        end
    end

    assign data_o = s2_q[N-1:1];
    assign rise_o = s2_q[0] & ~bclk_d_q;
endmodule

// File: rtl/olm_bitcnt.sv
// Module olm_bitcnt
// Finds word-clock boundaries on bit-clock rises and counts the bit
// position inside each half. Sets a sticky error when a half length
// differs from HALF. The first rise after reset only primes the edge
// detector; the first boundary locks the framing without a length check.
module olm_bitcnt #(
    parameter int unsigned HALF = 128,
    parameter int unsigned CW   = $clog2(HALF) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise_i,
    input  logic          wclk_i,
    output logic          bndry_o,
    output logic          locked_o,
    output logic          half_o,
    output logic [CW-1:0] pos_o,
    output logic          err_o
);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);
    localparam logic [CW-1:0] SAT  = '1;

    logic          seen_q, prev_q, locked_q, half_q, err_q;
    logic [CW-1:0] cnt_q;

    assign bndry_o  = rise_i & seen_q & (wclk_i != prev_q);
    assign locked_o = locked_q;
    assign half_o   = half_q;
    assign pos_o    = cnt_q;
    assign err_o    = err_q;

    // Purpose: track the word-clock level, the bit position and half length errors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q   <= 1'b0;
            prev_q   <= 1'b0;
            locked_q <= 1'b0;
            half_q   <= 1'b0;
            err_q    <= 1'b0;
            cnt_q    <= '0;
        end else if (rise_i) begin
            seen_q <= 1'b1;
            prev_q <= wclk_i;
            if (bndry_o) begin
                locked_q <= 1'b1;
                half_q   <= wclk_i;
                cnt_q    <= '0;
                if (locked_q && cnt_q != LAST) err_q <= 1'b1;
            end else if (cnt_q != SAT) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R7
    AST_NO_ERR_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !locked_o |-> !err_o); // R7
endmodule

// File: rtl/olm_lane.sv
// Module olm_lane
// Shifts one serial data line MSB first and emits each completed W-bit
// slot with its index. Only the first NSLOT slots of each half are
// taken; later bits and the bit at the boundary rise are discarded.
module olm_lane #(
    parameter int unsigned W     = 24,
    parameter int unsigned NSLOT = 3,
    parameter int unsigned SLW   = 2,
    parameter int unsigned BW    = $clog2(W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rise_i,
    input  logic           bndry_i,
    input  logic           locked_i,
    input  logic           sd_i,
    output logic           cap_o,
    output logic [SLW-1:0] slot_o,
    output logic [W-1:0]   word_o
);
    localparam logic [BW-1:0]  BIT_LAST = BW'(W - 1);
    localparam logic [SLW-1:0] SLOT_END = SLW'(NSLOT);

    logic [BW-1:0]  bit_q;
    logic [SLW-1:0] slot_q;
    logic [W-1:0]   sh_q;
    logic [W-1:0]   sh_next;

    assign sh_next = {sh_q[W-2:0], sd_i};

    // Purpose: shift data bits and hand out a word at each slot end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q  <= '0;
            slot_q <= '0;
            sh_q   <= '0;
            cap_o  <= 1'b0;
            slot_o <= '0;
            word_o <= '0;
        end else begin
            cap_o <= 1'b0;
            if (bndry_i) begin
                bit_q  <= '0;
                slot_q <= '0;
            end else if (rise_i && locked_i && slot_q < SLOT_END) begin
                sh_q <= sh_next;
                if (bit_q == BIT_LAST) begin
                    cap_o  <= 1'b1;
                    word_o <= sh_next;
                    slot_o <= slot_q;
                    bit_q  <= '0;
                    slot_q <= slot_q + 1'b1;
                end else begin
                    bit_q <= bit_q + 1'b1;
                end
            end
        end
    end

    AST_CAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_o |=> !cap_o); // R2
    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_o |-> slot_o < SLOT_END); // R5
endmodule

// File: rtl/olm_deser.sv
// Module olm_deser
// Top level: synchronises the pins, frames the halves and routes the
// slots of the main and auxiliary lanes into eight channel registers.
// Issues a one-cycle frame strobe after the last even-channel slot,
// provided the odd-channel half before it was complete.
module olm_deser
    import olm_pkg::*;
#(
    parameter int unsigned W     = SAMPLE_W,
    parameter int unsigned HALF  = HALF_BCLK,
    parameter int unsigned NMAIN = MAIN_SLOTS,
    parameter int unsigned NAUX  = AUX_SLOTS,
    parameter int unsigned NCH   = 2 * (NMAIN + NAUX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_i,
    input  logic             wclk_i,
    input  logic             sd_main_i,
    input  logic             sd_aux_i,
    output logic [NCH*W-1:0] ch_o,
    output logic             frame_vld_o,
    output logic             frame_err_o
);
    localparam int unsigned CW    = $clog2(HALF) + 1;
    localparam int unsigned SLW   = $clog2(NMAIN + 1);
    localparam int unsigned NLANE = 2;

    logic [2:0]     pins;
    logic           rise, bndry, locked, half;
    logic [CW-1:0]  pos;
    logic [NLANE-1:0]  cap;
    logic [SLW-1:0]    slot [NLANE];
    logic [W-1:0]      word [NLANE];
    logic [W-1:0]      ch_q [NCH];
    logic              left_done_q, vld_q;

    olm_sync #(.N(4)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .raw_i({sd_aux_i, sd_main_i, wclk_i, bclk_i}),
        .data_o(pins), .rise_o(rise)
    );

    olm_bitcnt #(.HALF(HALF), .CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .wclk_i(pins[0]),
        .bndry_o(bndry), .locked_o(locked), .half_o(half),
        .pos_o(pos), .err_o(frame_err_o)
    );

    // Lane 0 is the main line, lane 1 the auxiliary line.
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int unsigned NS = (g == 0) ? NMAIN : NAUX;
        olm_lane #(.W(W), .NSLOT(NS), .SLW(SLW)) u_lane (
            .clk(clk), .rst_n(rst_n), .rise_i(rise), .bndry_i(bndry),
            .locked_i(locked), .sd_i(pins[g+1]),
            .cap_o(cap[g]), .slot_o(slot[g]), .word_o(word[g])
        );
    end

    // Purpose: write captured slots into channels and raise the frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NCH; k++) ch_q[k] <= '0;
            left_done_q <= 1'b0;
            vld_q       <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            for (int g = 0; g < NLANE; g++) begin
                if (cap[g]) begin
                    int idx;
                    idx = ((g == 0) ? 0 : 2 * NMAIN) + 2 * int'(slot[g]) + int'(half);
                    if (idx < NCH) ch_q[idx] <= word[g];
                end
            end
            if (cap[0] && slot[0] == SLW'(NMAIN - 1)) begin
                if (!half) begin
                    left_done_q <= 1'b1;
                end else begin
                    left_done_q <= 1'b0;
                    vld_q       <= left_done_q;
                end
            end
        end
    end

    for (genvar k = 0; k < NCH; k++) begin : g_out
        assign ch_o[k*W +: W] = ch_q[k];
    end
    assign frame_vld_o = vld_q;

    // The bit position is consumed by the lanes through their own counters.
    logic unused_pos;
    assign unused_pos = ^pos;

    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld_o |=> !frame_vld_o); // R6
    AST_VLD_RIGHT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld_o |-> half); // R6
    AST_CH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cap == '0) |=> $stable(ch_o)); // R8
    AST_NO_CAP_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (cap == '0)); // R8
endmodule

// File: tb/sim_olm_deser.sv
// Bench for olm_deser: drives whole frames with computed channel words,
// padding bits set to junk, and halves of wrong length.
module sim_olm_deser;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk = 1'b0, wclk = 1'b1, sd_main = 1'b0, sd_aux = 1'b0;
    logic [191:0] ch_o;
    logic frame_vld_o, frame_err_o;
    int nchk = 0, nfail = 0, nstb = 0;

    always #10 clk = ~clk;

    olm_deser u0 (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .wclk_i(wclk),
        .sd_main_i(sd_main), .sd_aux_i(sd_aux),
        .ch_o(ch_o), .frame_vld_o(frame_vld_o), .frame_err_o(frame_err_o)
    );

    always @(posedge clk) if (frame_vld_o) nstb++;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] pat(int f, int c);
        if (f == 0) return 24'hFFFFFF ^ 24'(c);
        else if (f == 1) return 24'(24'h000001 << (3 * c));
        else return 24'((f * 32'h9E3779B1) ^ (c * 32'h7F4A7C15) ^ (f << c));
    endfunction

    task automatic bit_cycle();
        repeat (4) @(negedge clk);
        bclk = 1'b1;
        repeat (4) @(negedge clk);
        bclk = 1'b0;
    endtask

    task automatic idle(logic lvl, int n);
        for (int t = 0; t < n; t++) begin
            wclk = lvl; sd_main = t[0]; sd_aux = ~t[0];
            bit_cycle();
        end
    endtask

    task automatic send_half(logic h, int len, int f);
        for (int t = 0; t < len; t++) begin
            logic [23:0] w;
            logic junk;
            int p;
            p = t - 1;
            junk = (((t * 5 + f) % 3) == 0);
            wclk = h;
            if (t >= 1 && p < 72) begin
                w = pat(f, 2 * (p / 24) + int'(h));
                sd_main = w[23 - (p % 24)];
            end else sd_main = junk;
            if (t >= 1 && p < 24) begin
                w = pat(f, 6 + int'(h));
                sd_aux = w[23 - p];
            end else sd_aux = ~junk;
            bit_cycle();
        end
    endtask

    task automatic check_frame(int f);
        for (int c = 0; c < 8; c++) begin
            string tag;
            tag = (c >= 6) ? "R4 R5" : ((c % 2 == 0) ? "R2 R5" : "R3 R5");
            check(tag, 32'(ch_o[c*24 +: 24]), 32'(pat(f, c)));
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R1 ch", 32'(|ch_o), 32'd0);
        check("R1 vld", 32'(frame_vld_o), 32'd0);
        check("R1 err", 32'(frame_err_o), 32'd0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog R1: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        int s0;
        do_reset();
        idle(1'b1, 5);
        check("R8 nothing before lock", 32'(|ch_o), 32'd0);
        s0 = nstb;
        for (int f = 0; f < 6; f++) begin
            send_half(1'b0, 128, f);
            send_half(1'b1, 128, f);
            check_frame(f);
            check("R6 one strobe per frame", 32'(nstb - s0), 32'(f + 1));
            check("R7 no error on good frames", 32'(frame_err_o), 32'd0);
        end
        // R8: pins toggle with no bit-clock rise; words must hold.
        for (int k = 0; k < 20; k++) begin
            sd_main = k[0]; sd_aux = k[1]; wclk = k[2];
            repeat (3) @(negedge clk);
        end
        wclk = 1'b1;
        check_frame(5);
        check("R8 hold", 32'(ch_o[0 +: 24]), 32'(pat(5, 0)));
        // R7: short half.
        send_half(1'b0, 100, 9);
        send_half(1'b1, 128, 9);
        check("R7 short half", 32'(frame_err_o), 32'd1);
        send_half(1'b0, 128, 10);
        send_half(1'b1, 128, 10);
        check("R7 sticky", 32'(frame_err_o), 32'd1);
        check_frame(10);
        do_reset();
        // R6: lock in a high half gives no strobe.
        idle(1'b0, 3);
        s0 = nstb;
        send_half(1'b1, 128, 7);
        check("R6 no strobe without low half", 32'(nstb - s0), 32'd0);
        check("R7 first boundary unchecked", 32'(frame_err_o), 32'd0);
        send_half(1'b0, 128, 7);
        send_half(1'b1, 128, 7);
        check("R6 strobe after full frame", 32'(nstb - s0), 32'd1);
        check_frame(7);
        check("R7 still clear", 32'(frame_err_o), 32'd0);
        // R7: long half.
        send_half(1'b0, 130, 8);
        check("R7 before long half ends", 32'(frame_err_o), 32'd0);
        send_half(1'b1, 128, 8);
        check("R7 long half", 32'(frame_err_o), 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule